// File: doc/BRIEF.md
# Morse Element Timing Regenerator

This block turns hand-keyed Morse, as sent on a straight key or a semi-automatic key, into keying with exact proportions. It watches a clean, active-high key-down level. When the key goes down while the block is idle, it starts an element. That element is a mark of one unit (a dot) or three units (a dash), followed by one unit of space. The unit length is an input given in system clock cycles. For example, at 20 words per minute one unit is 60 ms, so a dash lasts 180 ms.

A single look at the key decides between dot and dash. The block samples the key on the clock edge that ends the first mark unit. If the key is still down on that edge, a dash flag is latched and the mark runs to three units. If it is up, the mark ends after one unit, so a short press is stretched to a full dot. The unit timer runs only while an element is in progress and starts again from zero for each new element.

The key is ignored from the edge that starts an element until the edge that ends its trailing space. A press that begins and ends inside that window therefore produces nothing. A press that is still down when the space ends starts the next element on that same edge, so back-to-back elements are separated by exactly one unit.

Top module: `morse_regen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `morseOut` and `dashFlag` are both 0 and the block is idle.
- R2: While the block is idle and `keyIn` is 0, `morseOut` stays 0.
- R3: If the block is idle and `keyIn` is 1 on a rising clock edge, `morseOut` is 1 immediately after that edge.
- R4: If `keyIn` is 0 on the edge that ends the first unit (the edge U cycles after the start edge), the mark is exactly U cycles long and `dashFlag` stays 0. A press shorter than U cycles still gives a U-cycle mark.
- R5: If `keyIn` is 1 on that edge, `dashFlag` becomes 1 after that edge and the mark is exactly 3U cycles long. A press of U+1 cycles or more is therefore a dash.
- R6: Every mark is followed by at least U cycles of `morseOut` = 0.
- R7: The key level is not looked at from the start edge of an element until the edge that ends its trailing space. A press that starts and ends inside that window produces no mark.
- R8: If `keyIn` is 1 on the edge that ends the trailing space, the next mark starts on that edge and the space is exactly U cycles. Otherwise the block goes idle, and the next mark starts on the first edge that samples `keyIn` = 1.
- R9: `dashFlag` is 1 only from the edge that decides a dash until the edge that ends that element's trailing space. Dots never raise it.
- R10: A `unitLen` of 0 behaves as a unit of 1 cycle. U is `unitLen`, or 1 when `unitLen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| unitLen | input | UNIT_W | Unit length in clock cycles; change it only while idle |
| keyIn | input | 1 | Debounced key level, 1 = key down |
| morseOut | output | 1 | Registered regenerated keying, 1 = mark |
| dashFlag | output | 1 | 1 while the current element has been judged a dash |

## Verification
Call the edge that first samples the key down the start edge. `morseOut` rises right after the start edge. The dot-or-dash decision and any rise of `dashFlag` come U edges after the start edge. The mark falls U or 3U edges after the start edge, and the trailing space ends U edges after that. A behavioural model in the bench counts cycles since the start edge and is compared with both outputs on every falling clock edge, so each result is checked in the exact cycle it is due. A monitor also records the length of every mark and every space, and these lengths are checked against values worked out from the press and release times of each scenario: nominal dots, short 58-cycle presses, long 63-cycle presses, presses made while an element is still running, a key held down, and a unit of zero.

// File: rtl/regen_pkg.sv
package regen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MARK1 = 3'd1,
    ST_MARK2 = 3'd2,
    ST_MARK3 = 3'd3,
    ST_GAP   = 3'd4
  } regenState_t;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic markNext;
    logic dashSet;
    logic dashClear;
  } regenStrobe_t;

endpackage

// File: rtl/regen_dp.sv
module regen_dp
  import regen_pkg::*;
#(
  parameter int UNIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [UNIT_W-1:0] unitLen,
  input  regenStrobe_t      strobe,
  output logic              unitTick,
  output logic              morseOut,
  output logic              dashFlag
);

  localparam int EXT_W = UNIT_W + 1;

  logic [UNIT_W-1:0] unitCnt;
  logic [EXT_W-1:0]  cntNext;

  // The unit ends once the cycles counted so far reach the unit length.
  // A zero length makes every cycle a tick.
  assign cntNext  = {1'b0, unitCnt} + EXT_W'(1);
  assign unitTick = (cntNext >= {1'b0, unitLen});

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClear) begin
      unitCnt <= '0;
    end else if (strobe.cntRun) begin
      unitCnt <= cntNext[UNIT_W-1:0];
    end
  end

  // Both outputs are registered so they change only on clock edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      morseOut <= 1'b0;
      dashFlag <= 1'b0;
    end else begin
      morseOut <= strobe.markNext;
      if (strobe.dashSet) begin
        dashFlag <= 1'b1;
      end else if (strobe.dashClear) begin
        dashFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/regen_ctrl.sv
module regen_ctrl
  import regen_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         keyIn,
  input  logic         unitTick,
  output regenStrobe_t strobe
);

  regenState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState        = state;
    strobe           = '0;
    strobe.cntRun    = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (keyIn) begin
          nextState       = ST_MARK1;
          strobe.cntClear = 1'b1;
        end
      end
      ST_MARK1: begin
        if (unitTick) begin
          strobe.cntClear = 1'b1;
          if (keyIn) begin
            strobe.dashSet = 1'b1;
            nextState      = ST_MARK2;
          end else begin
            nextState      = ST_GAP;
          end
        end
      end
      ST_MARK2: begin
        if (unitTick) begin
          strobe.cntClear = 1'b1;
          nextState       = ST_MARK3;
        end
      end
      ST_MARK3: begin
        if (unitTick) begin
          strobe.cntClear = 1'b1;
          nextState       = ST_GAP;
        end
      end
      ST_GAP: begin
        if (unitTick) begin
          strobe.cntClear  = 1'b1;
          strobe.dashClear = 1'b1;
          nextState        = keyIn ? ST_MARK1 : ST_IDLE;
        end
      end
      default: begin
        nextState = ST_IDLE;
      end
    endcase
    strobe.markNext = (nextState == ST_MARK1) || (nextState == ST_MARK2) ||
                      (nextState == ST_MARK3);
  end

endmodule

// File: rtl/morse_regen.sv
module morse_regen
  import regen_pkg::*;
#(
  parameter int UNIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [UNIT_W-1:0] unitLen,
  input  logic              keyIn,
  output logic              morseOut,
  output logic              dashFlag
);

  regenStrobe_t strobe;
  logic         unitTick;

  regen_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .keyIn    (keyIn),
    .unitTick (unitTick),
    .strobe   (strobe)
  );

  regen_dp #(.UNIT_W(UNIT_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .unitLen  (unitLen),
    .strobe   (strobe),
    .unitTick (unitTick),
    .morseOut (morseOut),
    .dashFlag (dashFlag)
  );

endmodule

// File: rtl/regen_chk.sv
module regen_chk #(
  parameter int UNIT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [UNIT_W-1:0] unitLen,
  input logic              morseOut,
  input logic              dashFlag
);

  int unsigned uEff;
  int unsigned markRun;
  int unsigned spaceRun;
  logic        seenMark;

  always_comb uEff = (unitLen == '0) ? 1 : int'(unitLen);

  // Counts of consecutive mark and space cycles, so the windows are
  // checked without deep history.
  always_ff @(posedge clk) begin
    if (rst) begin
      markRun  <= 0;
      spaceRun <= 0;
      seenMark <= 1'b0;
    end else begin
      markRun  <= morseOut ? markRun + 1 : 0;
      spaceRun <= morseOut ? 0 : spaceRun + 1;
      if (morseOut) seenMark <= 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!morseOut && !dashFlag));

  a_r4_dot_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(morseOut) && !dashFlag) |-> (markRun == uEff));

  a_r5_dash_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(morseOut) && dashFlag) |-> (markRun == 3 * uEff));

  a_r6_space_min: assert property (@(posedge clk) disable iff (rst)
    ($rose(morseOut) && seenMark) |-> (spaceRun >= uEff));

  a_r9_dash_in_mark: assert property (@(posedge clk) disable iff (rst)
    $rose(dashFlag) |-> morseOut);

  a_r9_dash_drop_in_space: assert property (@(posedge clk) disable iff (rst)
    $fell(dashFlag) |-> !$past(morseOut));

endmodule

bind morse_regen regen_chk #(.UNIT_W(UNIT_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .unitLen  (unitLen),
  .morseOut (morseOut),
  .dashFlag (dashFlag)
);

// File: tb/morse_regen_test.sv
module morse_regen_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        keyIn;
  logic [15:0] unitLen;
  logic        morseOut;
  logic        dashFlag;

  always #5 clk = ~clk;

  morse_regen #(.UNIT_W(16)) uut (
    .clk      (clk),
    .rst      (rst),
    .unitLen  (unitLen),
    .keyIn    (keyIn),
    .morseOut (morseOut),
    .dashFlag (dashFlag)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  // Behavioural reference: cycles since the start edge of an element.
  int uEff;
  bit mActive = 1'b0;
  bit mDash   = 1'b0;
  int mT      = 0;

  always_comb uEff = (unitLen == 16'd0) ? 1 : int'(unitLen);

  always @(posedge clk) begin
    if (rst) begin
      mActive = 1'b0;
      mDash   = 1'b0;
      mT      = 0;
    end else if (!mActive) begin
      if (keyIn) begin
        mActive = 1'b1;
        mDash   = 1'b0;
        mT      = 0;
      end
    end else begin
      mT = mT + 1;
      if (mT == uEff && keyIn) mDash = 1'b1;
      if (mT == (mDash ? 4 * uEff : 2 * uEff)) begin
        mDash = 1'b0;
        if (keyIn) mT = 0;
        else       mActive = 1'b0;
      end
    end
  end

  // Per-cycle comparison against the reference model.
  bit cmpOn = 1'b0;
  always @(negedge clk) begin
    if (cmpOn) begin
      logic expMorse, expDash;
      expMorse = mActive && (mT < (mDash ? 3 * uEff : uEff));
      expDash  = mActive && mDash;
      checks++;
      if (morseOut !== expMorse || dashFlag !== expDash) begin
        errors++;
        $display("FAIL %s cycle model: morseOut=%b dashFlag=%b expected %b %b",
                 curReq, morseOut, dashFlag, expMorse, expDash);
      end
    end
  end

  // Monitor of mark and space lengths.
  int marks[$];
  int spaces[$];
  int markCnt  = 0;
  int spaceCnt = 0;
  bit monSeen  = 1'b0;
  bit dashSeen = 1'b0;

  always @(negedge clk) begin
    if (dashFlag === 1'b1) dashSeen = 1'b1;
    if (morseOut === 1'b1) begin
      if (monSeen && spaceCnt > 0) spaces.push_back(spaceCnt);
      spaceCnt = 0;
      markCnt  = markCnt + 1;
    end else if (markCnt > 0) begin
      marks.push_back(markCnt);
      markCnt  = 0;
      monSeen  = 1'b1;
      spaceCnt = 1;
    end else if (monSeen) begin
      spaceCnt = spaceCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    marks.delete();
    spaces.delete();
    monSeen  = 1'b0;
    spaceCnt = 0;
    dashSeen = 1'b0;
  endtask

  task automatic press(input int down, input int up);
    keyIn = 1'b1;
    repeat (down) @(negedge clk);
    keyIn = 1'b0;
    repeat (up) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chkMarks(input string req, input int n, input int len);
    chk(marks.size() == n, req, "mark count", marks.size(), n);
    foreach (marks[i]) chk(marks[i] == len, req, "mark length", marks[i], len);
  endtask

  task automatic chkSpaces(input string req, input int n, input int len);
    chk(spaces.size() == n, req, "space count", spaces.size(), n);
    foreach (spaces[i]) chk(spaces[i] == len, req, "space length", spaces[i], len);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    finishRun();
  end

  initial begin
    rst     = 1'b1;
    keyIn   = 1'b0;
    unitLen = 16'd60;
    settle(3);
    cmpOn = 1'b1;
    // R1: outputs low in reset.
    chk(morseOut == 1'b0 && dashFlag == 1'b0, "R1", "outputs in reset",
        {morseOut, dashFlag}, 0);
    rst = 1'b0;
    settle(1);
    chk(morseOut == 1'b0 && dashFlag == 1'b0, "R1", "outputs after reset",
        {morseOut, dashFlag}, 0);

    // R2: idle with key up stays quiet.
    curReq = "R2";
    clearLog();
    settle(40);
    chk(marks.size() == 0 && morseOut == 1'b0, "R2", "idle marks", marks.size(), 0);

    // R3/R4: nominal 60-cycle press gives one 60-cycle dot, rising one edge later.
    curReq = "R3";
    @(negedge clk);
    keyIn = 1'b1;
    @(negedge clk);
    chk(morseOut == 1'b1, "R3", "mark after first key edge", morseOut, 1);
    curReq = "R4";
    repeat (59) @(negedge clk);
    keyIn = 1'b0;
    settle(200);
    chkMarks("R4", 1, 60);
    chk(dashSeen == 1'b0, "R4", "dash flag during dot", dashSeen, 0);

    // R4/R8: 58-cycle presses, 60 up: stretched dots, space held to 60.
    curReq = "R8";
    clearLog();
    @(negedge clk);
    for (int i = 0; i < 4; i++) press(58, 60);
    settle(200);
    chkMarks("R4", 4, 60);
    chkSpaces("R8", 3, 60);
    chk(dashSeen == 1'b0, "R4", "dash flag on short presses", dashSeen, 0);

    // R5/R7: 63-cycle presses become dashes; presses 2 and 4 fall inside a
    // running element and vanish; press 3 starts at cycle 246 -> space 66.
    curReq = "R7";
    clearLog();
    @(negedge clk);
    for (int i = 0; i < 4; i++) press(63, 60);
    settle(300);
    chkMarks("R5", 2, 180);
    chkSpaces("R7", 1, 66);
    chk(dashSeen == 1'b1, "R5", "dash flag raised", dashSeen, 1);
    chk(dashFlag == 1'b0, "R9", "dash flag after sequence", dashFlag, 0);

    // R5/R8: nominal dashes 180 down, 60 up: second press lands on the
    // space-ending edge and starts at once.
    curReq = "R8";
    clearLog();
    @(negedge clk);
    press(180, 60);
    press(180, 60);
    settle(300);
    chkMarks("R5", 2, 180);
    chkSpaces("R8", 1, 60);

    // R7: a 20-cycle press inside the trailing space of a dot is dropped.
    curReq = "R7";
    clearLog();
    @(negedge clk);
    press(10, 60);
    press(20, 200);
    settle(50);
    chkMarks("R7", 1, 60);
    chk(morseOut == 1'b0, "R7", "output after ignored press", morseOut, 0);

    // R6/R8/R9: key held for 300 cycles: dash, 60 space, then a dot.
    curReq = "R6";
    clearLog();
    @(negedge clk);
    press(300, 200);
    settle(10);
    chk(marks.size() == 2, "R6", "held key mark count", marks.size(), 2);
    if (marks.size() == 2) begin
      chk(marks[0] == 180, "R6", "held key first mark", marks[0], 180);
      chk(marks[1] == 60, "R6", "held key second mark", marks[1], 60);
    end
    chkSpaces("R6", 1, 60);
    chk(dashFlag == 1'b0, "R9", "dash flag idle", dashFlag, 0);

    // R10: unit length 0 acts as one cycle.
    curReq = "R10";
    @(negedge clk);
    rst     = 1'b1;
    unitLen = 16'd0;
    settle(2);
    rst = 1'b0;
    clearLog();
    @(negedge clk);
    press(1, 10);
    settle(2);
    chkMarks("R10", 1, 1);
    clearLog();
    @(negedge clk);
    press(2, 10);
    settle(2);
    chkMarks("R10", 1, 3);
    chk(dashSeen == 1'b1, "R10", "dash at unit one", dashSeen, 1);

    settle(5);
    finishRun();
  end

endmodule